// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry Rotate

This block is a purely combinational shifter that prepares the second operand of a data operation. It takes a data word, a shift kind, a shift distance of up to W-1 places and the current carry flag. It returns the shifted word and a carry-out, which a flag unit can use when the operation updates the flags.

It supports logical shifts in both directions, an arithmetic right shift that copies the sign bit, a plain right rotate, and a one-place rotate through the carry flag. In that rotate, the carry acts as a 33rd bit sitting above the top bit. The interface has no valid/ready handshake, because the block holds no state. The outputs settle from the inputs within the same cycle, so the block drops straight into an execute stage.

Top module: `opsh_top`

## Requirements
- R1: With kind 3'b000 (logical left) and distance n in 1..31, dout equals din shifted left by n with zeros entering at bit 0, and cout equals din[32-n].
- R2: Kind 3'b010 (arithmetic left) gives exactly the same dout and cout as kind 3'b000 for every input.
- R3: With kind 3'b001 (logical right) and n in 1..31, dout equals din shifted right by n with zeros entering at bit 31, and cout equals din[n-1].
- R4: With kind 3'b011 (arithmetic right) and n in 1..31, the vacated high bits of dout are copies of din[31], and cout equals din[n-1].
- R5: With kind 3'b100 (rotate right) and n in 1..31, bits leaving bit 0 re-enter at bit 31, and cout equals the new dout[31].
- R6: With kind 3'b101 (carry rotate), dout equals {cin, din[31:1]} and cout equals din[0]. The distance input has no effect.
- R7: For kinds 3'b000 to 3'b100 with distance 0, dout equals din and cout equals cin.
- R8: Kinds 3'b110 and 3'b111 pass din to dout unchanged and set cout to cin, whatever the distance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 32 | Word to be shifted |
| kind | input | 3 | Shift kind code (see requirements) |
| amt | input | 5 | Shift distance in places |
| cin | input | 1 | Current carry flag |
| dout | output | 32 | Shifted word |
| cout | output | 1 | Carry-out of the shift |

## Verification
The checker assumes that every input is a known 0/1 value whenever it is evaluated, and that the distance never exceeds 31. This holds by construction, because the port is five bits wide. The bench drives every input from the same process and only samples after a settling delay, so no check ever sees a half-updated input set. All eight kind codes are swept, including the two spare codes, together with distances 0, 1, 31 and values in between, on words with the sign bit set and with it clear.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  typedef enum logic [2:0] {
    SK_LSL  = 3'd0,
    SK_LSR  = 3'd1,
    SK_ASL  = 3'd2,
    SK_ASR  = 3'd3,
    SK_ROR  = 3'd4,
    SK_RRX  = 3'd5,
    SK_PAS6 = 3'd6,
    SK_PAS7 = 3'd7
  } shift_kind_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_WRAP = 2'd2
  } fill_e;
endpackage

// File: rtl/opsh_right_unit.sv
module opsh_right_unit #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SW-1:0]  amt,
  input  opsh_pkg::fill_e mode,
  output logic [W-1:0]   dout
);
  import opsh_pkg::*;

  always_comb begin
    logic [W-1:0] v;
    v = din;
    for (int k = 0; k < SW; k++) begin
      if (amt[k]) begin
        case (mode)
          FILL_SIGN: v = W'($signed(v) >>> (1 << k));
          FILL_WRAP: v = (v >> (1 << k)) | (v << (W - (1 << k)));
          default:   v = v >> (1 << k);
        endcase
      end
    end
    dout = v;
  end
endmodule

// File: rtl/opsh_left_unit.sv
module opsh_left_unit #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  always_comb begin
    logic [W-1:0] v;
    v = din;
    for (int k = 0; k < SW; k++) begin
      if (amt[k]) v = v << (1 << k);
    end
    dout = v;
  end
endmodule

// File: rtl/opsh_carry_pick.sv
module opsh_carry_pick #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          left,
  output logic          bit_out
);
  logic [SW-1:0] ridx;
  logic [SW-1:0] lidx;

  // last bit leaving: bit n-1 going right, bit W-n going left
  assign ridx    = amt - SW'(1);
  assign lidx    = SW'(0) - amt;
  assign bit_out = left ? din[lidx] : din[ridx];
endmodule

// File: rtl/opsh_top.sv
module opsh_top #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [2:0]    kind,
  input  logic [SW-1:0] amt,
  input  logic          cin,
  output logic [W-1:0]  dout,
  output logic          cout
);
  import opsh_pkg::*;

  shift_kind_e sk;
  fill_e       rmode;
  logic [W-1:0] left_v;
  logic [W-1:0] right_v;
  logic         edge_bit;
  logic         is_left;
  logic         zero_amt;

  assign sk       = shift_kind_e'(kind);
  assign is_left  = (sk == SK_LSL) || (sk == SK_ASL);
  assign zero_amt = (amt == '0);

  always_comb begin
    case (sk)
      SK_ASR:  rmode = FILL_SIGN;
      SK_ROR:  rmode = FILL_WRAP;
      default: rmode = FILL_ZERO;
    endcase
  end

  opsh_left_unit #(.W(W), .SW(SW)) u_left (
    .din(din), .amt(amt), .dout(left_v)
  );

  opsh_right_unit #(.W(W), .SW(SW)) u_right (
    .din(din), .amt(amt), .mode(rmode), .dout(right_v)
  );

  opsh_carry_pick #(.W(W), .SW(SW)) u_carry (
    .din(din), .amt(amt), .left(is_left), .bit_out(edge_bit)
  );

  always_comb begin
    dout = din;
    cout = cin;
    case (sk)
      SK_LSL, SK_ASL: if (!zero_amt) begin
        dout = left_v;
        cout = edge_bit;
      end
      SK_LSR, SK_ASR, SK_ROR: if (!zero_amt) begin
        dout = right_v;
        cout = edge_bit;
      end
      SK_RRX: begin
        dout = {cin, din[W-1:1]};
        cout = din[0];
      end
      default: begin
        dout = din;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/opsh_checks.sv
module opsh_checks #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input logic [W-1:0]  din,
  input logic [2:0]    kind,
  input logic [SW-1:0] amt,
  input logic          cin,
  input logic [W-1:0]  dout,
  input logic          cout
);
  logic [W-1:0] lowmask;
  assign lowmask = (W'(1) << amt) - W'(1);

  always_comb begin
    if ((kind == 3'd0 || kind == 3'd2) && amt != '0)
      AST_LEFT_LOW_CLEAR: assert ((dout & lowmask) == '0) else $error("left fill"); // R1
    if (kind == 3'd1 && amt != '0)
      AST_LSR_TOP_CLEAR: assert (dout[W-1] == 1'b0) else $error("lsr fill"); // R3
    if (kind == 3'd3)
      AST_ASR_SIGN_KEPT: assert (dout[W-1] == din[W-1]) else $error("asr sign"); // R4
    if (kind == 3'd4)
      AST_ROR_ONES_KEPT: assert ($countones(dout) == $countones(din)) else $error("ror pop"); // R5
    if (kind == 3'd4 && amt != '0)
      AST_ROR_CARRY_TOP: assert (cout == dout[W-1]) else $error("ror carry"); // R5
    if (kind == 3'd5)
      AST_RRX_FORM: assert (dout[W-1] == cin && cout == din[0] && dout[W-2:0] == din[W-1:1]) else $error("rrx"); // R6
    if (kind <= 3'd4 && amt == '0)
      AST_ZERO_AMT_PASS: assert (dout == din && cout == cin) else $error("zero amt"); // R7
    if (kind >= 3'd6)
      AST_SPARE_PASS: assert (dout == din && cout == cin) else $error("spare"); // R8
  end
endmodule

bind opsh_top opsh_checks #(.W(W), .SW(SW)) u_opsh_checks (
  .din(din), .kind(kind), .amt(amt), .cin(cin), .dout(dout), .cout(cout)
);

// File: tb/tb_opsh_top.sv
module tb_opsh_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] din;
  logic [2:0]  kind;
  logic [4:0]  amt;
  logic        cin;
  logic [31:0] dout;
  logic        cout;

  int total = 0;
  int bad   = 0;

  opsh_top dut (
    .din(din), .kind(kind), .amt(amt), .cin(cin), .dout(dout), .cout(cout)
  );

  // vector: din(32) kind(3) amt(5) cin(1) exp_dout(32) exp_cout(1) req(4)
  localparam int NV = 12;
  localparam logic [77:0] VEC [NV] = '{
    {32'h80000001, 3'd0, 5'd1,  1'b0, 32'h00000002, 1'b1, 4'd1},
    {32'hFFFFFFFF, 3'd0, 5'd31, 1'b0, 32'h80000000, 1'b1, 4'd1},
    {32'h0000000F, 3'd2, 5'd4,  1'b0, 32'h000000F0, 1'b0, 4'd2},
    {32'h80000000, 3'd1, 5'd31, 1'b0, 32'h00000001, 1'b0, 4'd3},
    {32'h00000002, 3'd1, 5'd1,  1'b1, 32'h00000001, 1'b0, 4'd3},
    {32'h80000010, 3'd3, 5'd4,  1'b0, 32'hF8000001, 1'b0, 4'd4},
    {32'h7FFFFFF0, 3'd3, 5'd4,  1'b1, 32'h07FFFFFF, 1'b0, 4'd4},
    {32'h00000001, 3'd4, 5'd1,  1'b0, 32'h80000000, 1'b1, 4'd5},
    {32'h12345678, 3'd4, 5'd8,  1'b0, 32'h78123456, 1'b0, 4'd5},
    {32'h00000003, 3'd5, 5'd17, 1'b1, 32'h80000001, 1'b1, 4'd6},
    {32'hDEADBEEF, 3'd1, 5'd0,  1'b1, 32'hDEADBEEF, 1'b1, 4'd7},
    {32'h12345678, 3'd6, 5'd9,  1'b0, 32'h12345678, 1'b0, 4'd8}
  };

  // bit-at-a-time reference, written from the requirements
  function automatic logic [32:0] model(logic [31:0] d, logic [2:0] k,
                                        logic [4:0] n, logic c);
    logic [31:0] v = d;
    logic        cc = c;
    case (k)
      3'd0, 3'd2: for (int i = 0; i < n; i++) begin cc = v[31]; v = {v[30:0], 1'b0}; end
      3'd1:       for (int i = 0; i < n; i++) begin cc = v[0]; v = {1'b0, v[31:1]}; end
      3'd3:       for (int i = 0; i < n; i++) begin cc = v[0]; v = {v[31], v[31:1]}; end
      3'd4:       for (int i = 0; i < n; i++) begin cc = v[0]; v = {v[0], v[31:1]}; end
      3'd5:       begin cc = d[0]; v = {c, d[31:1]}; end
      default:    ;
    endcase
    return {cc, v};
  endfunction

  function automatic string req_of(logic [2:0] k, logic [4:0] n);
    if (k >= 3'd6) return "R8";
    if (k == 3'd5) return "R6";
    if (n == 5'd0) return "R7";
    case (k)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R2";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] ed, logic ec);
    total++;
    if (dout !== ed || cout !== ec) begin
      bad++;
      $display("FAIL %s: din=%h kind=%0d amt=%0d cin=%b got dout=%h cout=%b exp dout=%h cout=%b",
               req, din, kind, amt, cin, dout, cout, ed, ec);
    end
  endtask

  task automatic apply(logic [31:0] d, logic [2:0] k, logic [4:0] n, logic c);
    @(posedge clk);
    din = d; kind = k; amt = n; cin = c;
    @(negedge clk);
  endtask

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [32:0] r;
    logic [31:0] pats [6];
    pats = '{32'h00000000, 32'hFFFFFFFF, 32'h80000001, 32'h7FFFFFFE, 32'hA5C3_0F96, 32'h1234_5678};

    // start-up state: all-zero inputs give zero outputs
    apply(32'h0, 3'd0, 5'd0, 1'b0);
    check("R7", 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [77:0] e = VEC[i];
      apply(e[77:46], e[45:43], e[42:38], e[37]);
      check($sformatf("R%0d", e[3:0]), e[36:5], e[4]);
    end

    // sweep every kind, distance and carry over a set of words
    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 8; k++)
        for (int n = 0; n < 32; n++)
          for (int c = 0; c < 2; c++) begin
            apply(pats[p], 3'(k), 5'(n), 1'(c));
            r = model(pats[p], 3'(k), 5'(n), 1'(c));
            check(req_of(3'(k), 5'(n)), r[31:0], r[32]);
          end

    // R2: arithmetic left matches logical left directly
    for (int n = 0; n < 32; n++) begin
      logic [31:0] ld;
      logic        lc;
      apply(32'hC0FF_EE11, 3'd0, 5'(n), 1'b1);
      ld = dout; lc = cout;
      apply(32'hC0FF_EE11, 3'd2, 5'(n), 1'b1);
      check("R2", ld, lc);
    end

    // R6: distance ignored by the carry rotate
    apply(32'h0000_0002, 3'd5, 5'd31, 1'b0);
    check("R6", 32'h0000_0001, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule